// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block holds two independent time-of-day alarms. Each alarm is four byte registers: seconds, minutes, hours and day. Bit 7 of every alarm byte is a mask. On each one-second update strobe the block compares both alarms with the current time bytes. A match sets a sticky request flag for that alarm. The host sees the flags in a read-only status byte and clears a flag by touching any register of its alarm, whether it reads or writes.

A control byte holds one interrupt enable per alarm. Alarm 0 drives an active-low level interrupt that stays asserted while its flag and enable are both set. Alarm 1 drives an active-high pulse whose length is a fixed number of 32.768 kHz reference ticks. By default that is 2048 ticks, which is 62.5 ms.

The pulse is produced by a two-state machine with states `PULSE_IDLE` and `PULSE_ACTIVE`:
- `PULSE_IDLE` moves to `PULSE_ACTIVE` when alarm 1 matches on an update strobe while its enable is set.
- `PULSE_ACTIVE` returns to `PULSE_IDLE` when the enable is clear, or when the last reference tick of the pulse arrives.
- In every other case the state holds.

The host accesses registers through a single-cycle strobe. The bus carries an address, a write qualifier and write data. Read data is combinational from the address.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, every alarm byte, both enables and both flags are 0, `irq0_n` is 1 and `irq1` is 0.
- R2: Register map: alarm 0 is at addresses 07h–0Ah and alarm 1 is at 0Bh–0Eh, in the order seconds, minutes, hours, day. A write stores the full byte and a read returns it. Control is at 0Fh: bit 0 is enable 0 and bit 1 is enable 1, and bits 7..2 read 0. Any other address reads 0.
- R3: A field matches when its mask bit 7 is 1, or when its bits 6..0 equal bits 6..0 of the current byte. Bit 7 of the current byte is ignored. An alarm matches only when all four fields match, and it is evaluated only in a cycle where `sec_tick` is 1.
- R4: The masks select the repeat rate. All four masks set fires on every update. Unmasking seconds, then minutes, then hours narrows the match to once per minute, hour or day. With no mask set the alarm fires once a week, and a differing day value blocks it.
- R5: A match sets that alarm's flag in the cycle after the strobe, and the flag stays set. The status byte is at address 10h: bit 0 is flag 0 and bit 1 is flag 1, and bits 7..2 read 0. Writes to 10h have no effect.
- R6: Any strobe, read or write, to one of the four addresses of alarm k clears flag k on the next edge. It leaves the other alarm's flag unchanged. If a match of alarm k happens in the same cycle, the set wins.
- R7: `irq0_n` is 0 exactly while flag 0 and enable 0 are both 1.
- R8: When alarm 1 matches while enable 1 is 1 and no pulse is running, `irq1` goes high from the next cycle. It stays high until the PULSE_TICKS-th following `ref_tick` edge, so it is high for 2048 ticks by default. A match during a pulse does not restart it.
- R9: When enable 1 is 0, a running pulse ends on the next edge and `irq1` stays 0.
- R10: The hours alarm is compared with the whole hours byte, including the 12/24-hour bit 6 and the PM bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe marking a one-second time update |
| ref_tick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| cur_day | input | 8 | Current day-of-week byte |
| acc_stb | input | 1 | Host access strobe (read or write) |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` |
| irq0_n | output | 1 | Alarm 0 interrupt, active-low level |
| irq1 | output | 1 | Alarm 1 interrupt, active-high timed pulse |

## Verification
Directed patterns cover three groups of cases:
- Each mask combination, tried with values that differ only in the field just unmasked. This separates per-second, per-minute and weekly matching.
- Hours bytes that differ only in the PM bit. These show that the whole byte is compared.
- A current seconds byte with bit 7 set. This shows that the current byte's top bit is ignored.

Flag clearing is tried with reads, with writes, with access to the other alarm, and with a match in the same cycle. These show which alarm is cleared and that a set wins over a clear.

A long stretch of reference ticks measures the exact pulse length, and a second match inside the pulse shows that the pulse is not restarted.

A seeded random phase mixes host writes, reads, control changes and update strobes over a small set of time values. Matches therefore occur often, and the status, read data and both interrupts are compared each cycle with a bench model.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int NUM_ALARMS  = 2;
    localparam int NUM_FIELDS  = 4;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 5;
    localparam int ALM_BASE    = 7;
    localparam int CTRL_ADDR   = ALM_BASE + NUM_ALARMS * NUM_FIELDS;
    localparam int STAT_ADDR   = CTRL_ADDR + 1;

    typedef enum logic {
        PULSE_IDLE,
        PULSE_ACTIVE
    } pulse_state_t;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int NA = NUM_ALARMS,
    parameter int NF = NUM_FIELDS,
    parameter int DW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_stb,
    input  logic                acc_we,
    input  logic [AW-1:0]       acc_addr,
    input  logic [DW-1:0]       acc_wdata,
    input  logic [NA-1:0]       flags_i,
    output logic [DW-1:0]       acc_rdata,
    output logic [NA*NF*DW-1:0] alarms_o,
    output logic [NA-1:0]       en_o,
    output logic [NA-1:0]       hit_o
);
    localparam int NREG = NA * NF;

    logic [DW-1:0] alm_q [NREG];
    logic [NA-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) alm_q[i] <= '0;
            en_q <= '0;
        end else if (acc_stb && acc_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (acc_addr == AW'(ALM_BASE + i)) alm_q[i] <= acc_wdata;
            end
            if (acc_addr == AW'(CTRL_ADDR)) en_q <= acc_wdata[NA-1:0];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign alarms_o[g*DW +: DW] = alm_q[g];
    end

    assign en_o = en_q;

    always_comb begin
        hit_o = '0;
        for (int k = 0; k < NA; k++) begin
            for (int f = 0; f < NF; f++) begin
                if (acc_stb && acc_addr == AW'(ALM_BASE + k*NF + f)) hit_o[k] = 1'b1;
            end
        end
    end

    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (acc_addr == AW'(ALM_BASE + i)) acc_rdata = alm_q[i];
        end
        if (acc_addr == AW'(CTRL_ADDR)) acc_rdata[NA-1:0] = en_q;
        if (acc_addr == AW'(STAT_ADDR)) acc_rdata[NA-1:0] = flags_i;
    end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = BYTE_W
) (
    input  logic [NF*DW-1:0] alarm_i,
    input  logic [NF*DW-1:0] cur_i,
    output logic             match_o
);
    logic [NF-1:0] field_ok;

    for (genvar f = 0; f < NF; f++) begin : g_field
        logic [DW-1:0] a_b;
        logic [DW-1:0] c_b;
        assign a_b = alarm_i[f*DW +: DW];
        assign c_b = cur_i[f*DW +: DW];
        assign field_ok[f] = a_b[DW-1] || (a_b[DW-2:0] == c_b[DW-2:0]);
    end

    assign match_o = &field_ok;
endmodule

// File: rtl/tod_alarm_pulse.sv
module tod_alarm_pulse
    import tod_alarm_pkg::*;
#(
    parameter int PULSE_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic en_i,
    input  logic ref_tick,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_TICKS + 1);

    pulse_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PULSE_IDLE: begin
                if (trig_i && en_i) begin
                    state_d = PULSE_ACTIVE;
                    cnt_d   = '0;
                end
            end
            PULSE_ACTIVE: begin
                if (!en_i) begin
                    state_d = PULSE_IDLE;
                end else if (ref_tick) begin
                    if (cnt_q == CW'(PULSE_TICKS - 1)) state_d = PULSE_IDLE;
                    else cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PULSE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse_o = (state_q == PULSE_ACTIVE);
    end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter int PULSE_TICKS = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              ref_tick,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] cur_day,
    input  logic              acc_stb,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    output logic              irq0_n,
    output logic              irq1
);
    localparam int NA = NUM_ALARMS;
    localparam int NF = NUM_FIELDS;
    localparam int DW = BYTE_W;
    localparam int SW = NF * DW;

    logic [NA*SW-1:0] alarms_w;
    logic [SW-1:0]    cur_w;
    logic [NA-1:0]    en_w, hit_w, match_w, flag_q;

    assign cur_w = {cur_day, cur_hour, cur_min, cur_sec};

    tod_alarm_regs #(.NA(NA), .NF(NF), .DW(DW), .AW(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_stb   (acc_stb),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .flags_i   (flag_q),
        .acc_rdata (acc_rdata),
        .alarms_o  (alarms_w),
        .en_o      (en_w),
        .hit_o     (hit_w)
    );

    for (genvar k = 0; k < NA; k++) begin : g_alarm
        tod_alarm_match #(.NF(NF), .DW(DW)) match_i (
            .alarm_i (alarms_w[k*SW +: SW]),
            .cur_i   (cur_w),
            .match_o (match_w[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int k = 0; k < NA; k++) begin
                if (sec_tick && match_w[k]) flag_q[k] <= 1'b1;
                else if (hit_w[k])          flag_q[k] <= 1'b0;
            end
        end
    end

    assign irq0_n = ~(flag_q[0] & en_w[0]);

    tod_alarm_pulse #(.PULSE_TICKS(PULSE_TICKS)) pulse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (sec_tick & match_w[1]),
        .en_i     (en_w[1]),
        .ref_tick (ref_tick),
        .pulse_o  (irq1)
    );
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk
    import tod_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              acc_stb,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [BYTE_W-1:0] acc_rdata,
    input logic [1:0]        flags,
    input logic [1:0]        en,
    input logic              irq0_n,
    input logic              irq1
);
    AST_FLAG0_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(sec_tick)); // R5
    AST_FLAG1_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(sec_tick)); // R5
    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == ADDR_W'(STAT_ADDR)) |-> (acc_rdata[7:2] == 6'd0)); // R5
    AST_CLEAR_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !sec_tick && acc_addr >= ADDR_W'(ALM_BASE)
         && acc_addr < ADDR_W'(ALM_BASE + NUM_FIELDS)) |=> !flags[0]); // R6
    AST_IRQ0_NEEDS_FLAG_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq0_n |-> (flags[0] && en[0])); // R7
    AST_IRQ1_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq1) |-> $past(sec_tick)); // R8
    AST_IRQ1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |-> $past(en[1])); // R9
endmodule

bind tod_alarm_unit tod_alarm_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .acc_stb   (acc_stb),
    .acc_addr  (acc_addr),
    .acc_rdata (acc_rdata),
    .flags     (flag_q),
    .en        (en_w),
    .irq0_n    (irq0_n),
    .irq1      (irq1)
);

// File: tb/tod_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module tod_alarm_unit_tb_top;
    localparam int PT = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, ref_tick = 1'b0;
    logic acc_stb = 1'b0, acc_we = 1'b0;
    logic [4:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic irq0_n, irq1;
    logic [7:0] t_cur [4];

    always #2 clk = ~clk;

    tod_alarm_unit #(.PULSE_TICKS(PT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_tick(ref_tick),
        .cur_sec(t_cur[0]), .cur_min(t_cur[1]), .cur_hour(t_cur[2]), .cur_day(t_cur[3]),
        .acc_stb(acc_stb), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .irq0_n(irq0_n), .irq1(irq1)
    );

    int n_tot = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] m_alm [8];
    bit [1:0] m_en, m_flag;
    bit m_pulse;
    int m_cnt;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit fmatch(input int k);
        for (int f = 0; f < 4; f++) begin
            logic [7:0] a;
            a = m_alm[k*4 + f];
            if (!a[7] && a[6:0] != t_cur[f][6:0]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic set_time(input logic [7:0] s, m, h, d);
        t_cur[0] = s; t_cur[1] = m; t_cur[2] = h; t_cur[3] = d;
    endtask

    task automatic step(input bit stb, we, input logic [4:0] a, input logic [7:0] d,
                        input bit tk, rf);
        bit [1:0] evt, hit, nflag;
        bit npulse;
        int ncnt;
        acc_stb = stb; acc_we = we; acc_addr = a; acc_wdata = d;
        sec_tick = tk; ref_tick = rf;
        for (int k = 0; k < 2; k++) begin
            evt[k] = tk && fmatch(k);
            hit[k] = stb && a >= 5'(7 + 4*k) && a < 5'(11 + 4*k);
            nflag[k] = evt[k] ? 1'b1 : (hit[k] ? 1'b0 : m_flag[k]);
        end
        npulse = m_pulse; ncnt = m_cnt;
        if (!m_pulse) begin
            if (evt[1] && m_en[1]) begin npulse = 1'b1; ncnt = 0; end
        end else if (!m_en[1]) begin
            npulse = 1'b0;
        end else if (rf) begin
            if (m_cnt == PT - 1) npulse = 1'b0;
            else ncnt = m_cnt + 1;
        end
        @(negedge clk);
        m_flag = nflag; m_pulse = npulse; m_cnt = ncnt;
        if (stb && we) begin
            if (a >= 5'd7 && a <= 5'd14) m_alm[int'(a) - 7] = d;
            if (a == 5'd15) m_en = d[1:0];
        end
        acc_stb = 1'b0; acc_we = 1'b0; sec_tick = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] v);
        acc_addr = a;
        #0.5;
        v = acc_rdata;
    endtask

    task automatic compare(input string req);
        logic [7:0] v;
        peek(5'h10, v);
        check(v == {6'd0, m_flag}, {req, " status"}, v, {6'd0, m_flag});
        check(irq0_n == !(m_flag[0] && m_en[0]), "R7 irq0_n", irq0_n, !(m_flag[0] && m_en[0]));
        check(irq1 == m_pulse, {req, " irq1"}, irq1, m_pulse);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        step(1, 1, a, d, 0, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tot++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        int hi;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) m_alm[i] = '0;
        m_en = '0; m_flag = '0; m_pulse = 0; m_cnt = 0;
        set_time(8'h56, 8'h34, 8'h12, 8'h03);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(5'h10, v); check(v == 0, "R1 status", v, 0);
        peek(5'h07, v); check(v == 0, "R1 alarm byte", v, 0);
        peek(5'h0F, v); check(v == 0, "R1 control", v, 0);
        check(irq0_n == 1 && irq1 == 0, "R1 irq", {irq0_n, irq1}, 2'b10);

        // R2 register map and readback
        for (int f = 0; f < 4; f++) wr(5'(7 + f), 8'h80);
        wr(5'h0F, 8'hFF);
        peek(5'h0A, v); check(v == 8'h80, "R2 readback", v, 8'h80);
        peek(5'h0F, v); check(v == 8'h03, "R2 control upper zero", v, 8'h03);
        peek(5'h13, v); check(v == 0, "R2 unmapped", v, 0);

        // R4 all masks: every update
        step(0, 0, 0, 0, 1, 0); compare("R4 per-second");
        check(!irq0_n, "R7 irq0 low", irq0_n, 0);
        step(0, 0, 0, 0, 0, 0); compare("R5 sticky");
        // R6 clear on read of alarm 0
        step(1, 0, 5'h08, 0, 0, 0); compare("R6 read clear");
        check(irq0_n, "R7 irq0 high after clear", irq0_n, 1);

        // R8 seconds-only alarm 1, pulse length and no retrigger
        wr(5'h0B, 8'h56); wr(5'h0C, 8'h80); wr(5'h0D, 8'h80); wr(5'h0E, 8'h80);
        step(0, 0, 0, 0, 1, 0); compare("R8 pulse start");
        hi = irq1 ? 1 : 0;
        for (int i = 0; i < PT + 20; i++) begin
            step(0, 0, 0, 0, (i == 100), 1);
            compare("R8 pulse run");
            if (irq1) hi++;
        end
        check(hi == PT, "R8 pulse length", hi, PT);
        set_time(8'h57, 8'h34, 8'h12, 8'h03);
        step(1, 0, 5'h0B, 0, 1, 0); compare("R4 seconds mismatch");

        // R3 current bit 7 ignored
        set_time(8'hD6, 8'h34, 8'h12, 8'h03);
        step(0, 0, 0, 0, 1, 0); compare("R3 current bit7 ignored");
        step(1, 0, 5'h0E, 0, 0, 0); compare("R6 clear alarm1 only");

        // R4 weekly, R10 12-hour PM
        wr(5'h07, 8'h56); wr(5'h08, 8'h34); wr(5'h09, 8'h52); wr(5'h0A, 8'h03);
        set_time(8'h56, 8'h34, 8'h52, 8'h04);
        step(0, 0, 0, 0, 1, 0); compare("R4 weekly day mismatch");
        set_time(8'h56, 8'h34, 8'h72, 8'h03);
        step(0, 0, 0, 0, 1, 0); compare("R10 PM bit mismatch");
        check(m_flag[0] == 0, "R10 model", m_flag[0], 0);
        set_time(8'h56, 8'h34, 8'h52, 8'h03);
        step(0, 0, 0, 0, 1, 0); compare("R10 full match");
        check(m_flag[0] == 1, "R4 weekly hit", m_flag[0], 1);

        // R6 set wins over same-cycle clear, R5 status write ignored
        step(1, 0, 5'h07, 0, 1, 0); compare("R6 set wins");
        wr(5'h10, 8'h00); compare("R5 status write ignored");

        // R9 enable off ends a running pulse
        step(0, 0, 0, 0, 1, 0); compare("R8 second pulse");
        repeat (5) begin step(0, 0, 0, 0, 0, 1); compare("R8 running"); end
        wr(5'h0F, 8'h01); compare("R9 en write");
        step(0, 0, 0, 0, 0, 1); compare("R9 pulse aborted");
        check(irq1 == 0, "R9 irq1 low", irq1, 0);
        step(0, 0, 0, 0, 1, 0); compare("R9 no pulse while disabled");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] s_set [3], m_set [2], h_set [3];
            int op;
            s_set = '{8'h00, 8'h56, 8'h59};
            m_set = '{8'h34, 8'h00};
            h_set = '{8'h12, 8'h52, 8'h72};
            if ($urandom % 8 == 0)
                set_time(s_set[$urandom % 3], m_set[$urandom % 2], h_set[$urandom % 3],
                         8'($urandom % 2 + 3));
            op = $urandom % 10;
            if (op < 2) begin
                int f;
                f = $urandom % 4;
                v = (f == 0) ? s_set[$urandom % 3] : (f == 1) ? m_set[$urandom % 2] :
                    (f == 2) ? h_set[$urandom % 3] : 8'($urandom % 2 + 3);
                if ($urandom % 3 == 0) v[7] = 1'b1;
                step(1, 1, 5'(7 + 4*($urandom % 2) + f), v, $urandom % 3 == 0, $urandom % 2);
            end else if (op == 2) begin
                step(1, 1, 5'h0F, 8'($urandom), $urandom % 3 == 0, $urandom % 2);
            end else if (op == 3) begin
                step(1, 0, 5'($urandom % 20), 0, $urandom % 3 == 0, $urandom % 2);
            end else begin
                step(0, 0, 0, 0, $urandom % 3 == 0, $urandom % 2);
            end
            compare("R3 R5 R6 R8 R9 random");
            begin
                int r;
                r = $urandom % 8;
                peek(5'(7 + r), v);
                check(v == m_alm[r], "R2 random readback", v, m_alm[r]);
            end
        end

        finished = 1'b1;
        finish_run();
    end
endmodule